// File: doc/BRIEF.md
# CAN Remote Request Responder

This block sits behind a CAN frame decoder and acts on incoming remote request frames. Each decoded frame arrives as a descriptor with a one-cycle valid strobe. A remote request never lands in a receive mailbox. It does one of two things. It can start an automatic data-frame reply from every transmit mailbox whose identifier it matches exactly. Or, when the receive FIFO is enabled and one of the FIFO acceptance filters takes it, it is handed to the FIFO as a write.

Matching against mailboxes ignores all acceptance masks. The full 29-bit identifier field and the IDE bit must be equal, and only mailboxes configured for remote response take part. Each FIFO filter has a format that sets how many identifier bits it compares. Formats A and B also carry a per-filter switch that allows or refuses remote frames. Format C always takes a remote frame whose identifier matches. The block raises per-mailbox request pulses toward an external transmit arbiter. These requests carry normal priority, and the arbiter decides the order. The reply length is the mailbox's own configured length and never comes from the request.

Top module: `can_rrq_responder`

## Requirements
- R1: While and right after reset, `tx_req` is all zero and `fifo_wr` is 0.
- R2: A remote frame (`rx_rtr`=1) whose 29-bit `rx_id` and `rx_ide` both equal those of a mailbox with `mb_rr_en` set raises that mailbox's `tx_req` bit. The rise comes exactly two clock edges after the edge that samples `rx_valid`, and the bit stays high for one cycle only.
- R3: Mailbox matching uses no mask. A difference in any single identifier bit, or in IDE, gives no request.
- R4: A data frame (`rx_rtr`=0) never produces `tx_req` or `fifo_wr`.
- R5: `rx_dlc` has no effect on any output.
- R6: A mailbox with its `mb_rr_en` bit clear never has its `tx_req` bit raised.
- R7: When several mailboxes match one frame, all of their `tx_req` bits rise in the same cycle.
- R8: If `fifo_en`=1 and at least one filter accepts the remote frame, `fifo_wr` pulses once with `tx_req` all zero. `fifo_idx` then gives the lowest-numbered accepting filter.
- R9: A filter in format A or B accepts a remote frame only when its `flt_rtr_ok` bit is 1. When no filter accepts, the auto-reply path applies.
- R10: A format C filter accepts a matching remote frame whatever its `flt_rtr_ok` bit holds.
- R11: With `fifo_en`=0 the filters are ignored and matching mailboxes are requested.
- R12: Filter format code 2'b00 (A) compares all 29 identifier bits. Code 2'b01 (B) compares bits [28:15], and code 2'b10 (C) compares bits [28:21]. All three also require IDE equality. Code 2'b11 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for a decoded received frame |
| rx_id | input | 29 | Received identifier (standard IDs in bits [10:0]) |
| rx_ide | input | 1 | Received frame uses an extended identifier |
| rx_rtr | input | 1 | Received frame is a remote request |
| rx_dlc | input | 4 | Received length code (ignored) |
| fifo_en | input | 1 | Receive FIFO enabled |
| mb_rr_en | input | NUM_MB | Mailbox is a transmit mailbox answering remote requests |
| mb_id | input | NUM_MB*29 | Mailbox identifiers, mailbox k in bits [29k+28:29k] |
| mb_ide | input | NUM_MB | Mailbox identifier is extended |
| flt_fmt | input | NUM_FLT*2 | Filter format codes, filter k in bits [2k+1:2k] |
| flt_rtr_ok | input | NUM_FLT | Format A/B filter accepts remote frames |
| flt_id | input | NUM_FLT*29 | Filter target identifiers |
| flt_ide | input | NUM_FLT | Filter target IDE |
| tx_req | output | NUM_MB | Per-mailbox transmit request pulse to the arbiter |
| fifo_wr | output | 1 | Write strobe toward the receive FIFO |
| fifo_idx | output | IDX_W | Index of the accepting filter, valid with `fifo_wr` |

## Verification
The checker assumes that mailbox and filter configuration and `fifo_en` stay steady while a frame is in the two-stage pipeline. It also assumes that `rx_valid` is low during reset, so every `$past` look-back sees defined inputs. The bench changes configuration only between frames, after the previous result has drained, and it drops `rx_valid` in the cycle after each strobe. Every output request can therefore be traced back to exactly one remote frame two edges earlier.

// File: rtl/can_rrq_pkg.sv
package can_rrq_pkg;
  localparam int ID_W   = 29;
  localparam int B_LO   = 15;   // format B compares [28:15]
  localparam int C_LO   = 21;   // format C compares [28:21]

  typedef enum logic [1:0] {
    FMT_FULL  = 2'b00,
    FMT_WIDE  = 2'b01,
    FMT_NARROW = 2'b10,
    FMT_OFF   = 2'b11
  } flt_fmt_e;

  typedef struct packed {
    logic            vld;
    logic [ID_W-1:0] id;
    logic            ide;
  } rrq_frame_t;
endpackage

// File: rtl/rrq_mb_match.sv
module rrq_mb_match
  import can_rrq_pkg::*;
(
  input  rrq_frame_t      frm,
  input  logic            rr_en,
  input  logic [ID_W-1:0] tgt_id,
  input  logic            tgt_ide,
  output logic            hit
);
  // exact compare, no mask
  always_comb begin
    hit = frm.vld && rr_en && (frm.ide == tgt_ide) && (frm.id == tgt_id);
  end
endmodule

// File: rtl/rrq_flt_match.sv
module rrq_flt_match
  import can_rrq_pkg::*;
(
  input  rrq_frame_t      frm,
  input  logic [1:0]      fmt,
  input  logic            rtr_ok,
  input  logic [ID_W-1:0] tgt_id,
  input  logic            tgt_ide,
  output logic            hit
);
  logic ide_eq, full_eq, wide_eq, narrow_eq;

  always_comb begin
    ide_eq    = (frm.ide == tgt_ide);
    full_eq   = (frm.id == tgt_id);
    wide_eq   = (frm.id[ID_W-1:B_LO] == tgt_id[ID_W-1:B_LO]);
    narrow_eq = (frm.id[ID_W-1:C_LO] == tgt_id[ID_W-1:C_LO]);
    hit = 1'b0;
    if (frm.vld && ide_eq) begin
      unique case (flt_fmt_e'(fmt))
        FMT_FULL:   hit = full_eq && rtr_ok;
        FMT_WIDE:   hit = wide_eq && rtr_ok;
        FMT_NARROW: hit = narrow_eq;
        default:    hit = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/can_rrq_responder.sv
module can_rrq_responder
  import can_rrq_pkg::*;
#(
  parameter int NUM_MB  = 4,
  parameter int NUM_FLT = 4,
  localparam int IDX_W  = (NUM_FLT > 1) ? $clog2(NUM_FLT) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_valid,
  input  logic [ID_W-1:0]         rx_id,
  input  logic                    rx_ide,
  input  logic                    rx_rtr,
  input  logic [3:0]              rx_dlc,
  input  logic                    fifo_en,
  input  logic [NUM_MB-1:0]       mb_rr_en,
  input  logic [NUM_MB*ID_W-1:0]  mb_id,
  input  logic [NUM_MB-1:0]       mb_ide,
  input  logic [NUM_FLT*2-1:0]    flt_fmt,
  input  logic [NUM_FLT-1:0]      flt_rtr_ok,
  input  logic [NUM_FLT*ID_W-1:0] flt_id,
  input  logic [NUM_FLT-1:0]      flt_ide,
  output logic [NUM_MB-1:0]       tx_req,
  output logic                    fifo_wr,
  output logic [IDX_W-1:0]        fifo_idx
);
  // the request length never matters: replies use the mailbox length
  logic dlc_unused;
  assign dlc_unused = ^rx_dlc;

  // stage 1: capture remote frames only
  rrq_frame_t s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
    end else begin
      s1.vld <= rx_valid && rx_rtr;
      s1.id  <= rx_id;
      s1.ide <= rx_ide;
    end
  end

  logic [NUM_MB-1:0]  mb_hit;
  logic [NUM_FLT-1:0] flt_hit;

  for (genvar m = 0; m < NUM_MB; m++) begin : g_mb
    rrq_mb_match i_mb (
      .frm     (s1),
      .rr_en   (mb_rr_en[m]),
      .tgt_id  (mb_id[m*ID_W +: ID_W]),
      .tgt_ide (mb_ide[m]),
      .hit     (mb_hit[m])
    );
  end

  for (genvar f = 0; f < NUM_FLT; f++) begin : g_flt
    rrq_flt_match i_flt (
      .frm     (s1),
      .fmt     (flt_fmt[f*2 +: 2]),
      .rtr_ok  (flt_rtr_ok[f]),
      .tgt_id  (flt_id[f*ID_W +: ID_W]),
      .tgt_ide (flt_ide[f]),
      .hit     (flt_hit[f])
    );
  end

  // lowest accepting filter wins the index
  logic [IDX_W-1:0] first_flt;
  always_comb begin
    first_flt = '0;
    for (int i = NUM_FLT - 1; i >= 0; i--) begin
      if (flt_hit[i]) first_flt = i[IDX_W-1:0];
    end
  end

  logic to_fifo;
  assign to_fifo = fifo_en && (|flt_hit);

  // stage 2: registered decision
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_req   <= '0;
      fifo_wr  <= 1'b0;
      fifo_idx <= '0;
    end else begin
      tx_req   <= to_fifo ? '0 : mb_hit;
      fifo_wr  <= to_fifo;
      fifo_idx <= to_fifo ? first_flt : '0;
    end
  end
endmodule

// File: rtl/rrq_chk.sv
module rrq_chk #(
  parameter int NUM_MB  = 4,
  parameter int NUM_FLT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              rx_valid,
  input logic              rx_rtr,
  input logic              fifo_en,
  input logic [NUM_MB-1:0] mb_rr_en,
  input logic [NUM_MB-1:0] tx_req,
  input logic              fifo_wr
);
  // R4
  only_remote_chk: assert property (@(posedge clk) disable iff (rst)
    ((|tx_req) || fifo_wr) |-> ($past(rx_valid, 2) && $past(rx_rtr, 2)));

  // R8
  fifo_excl_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> (tx_req == '0));

  // R11
  fifo_gate_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> $past(fifo_en));

  // R6
  rr_en_chk: assert property (@(posedge clk) disable iff (rst)
    (tx_req & ~$past(mb_rr_en)) == '0);

  // R2
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ((|tx_req) && !$past(rx_valid)) |=> (tx_req == '0));
endmodule

bind can_rrq_responder rrq_chk #(.NUM_MB(NUM_MB), .NUM_FLT(NUM_FLT)) i_chk (
  .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_rtr(rx_rtr),
  .fifo_en(fifo_en), .mb_rr_en(mb_rr_en), .tx_req(tx_req), .fifo_wr(fifo_wr)
);

// File: tb/test_can_rrq_responder.sv
module test_can_rrq_responder;
  localparam int NMB = 4;
  localparam int NFL = 4;
  localparam int IW  = 29;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic            rx_valid = 1'b0;
  logic [IW-1:0]   rx_id = '0;
  logic            rx_ide = 1'b0, rx_rtr = 1'b0, fifo_en = 1'b0;
  logic [3:0]      rx_dlc = '0;
  logic [NMB-1:0]  mb_rr_en, mb_ide;
  logic [NMB*IW-1:0] mb_id;
  logic [NFL*2-1:0]  flt_fmt;
  logic [NFL-1:0]  flt_rtr_ok, flt_ide;
  logic [NFL*IW-1:0] flt_id;
  logic [NMB-1:0]  tx_req;
  logic            fifo_wr;
  logic [1:0]      fifo_idx;

  can_rrq_responder #(.NUM_MB(NMB), .NUM_FLT(NFL)) i_can_rrq_responder (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_ide(rx_ide),
    .rx_rtr(rx_rtr), .rx_dlc(rx_dlc), .fifo_en(fifo_en), .mb_rr_en(mb_rr_en),
    .mb_id(mb_id), .mb_ide(mb_ide), .flt_fmt(flt_fmt), .flt_rtr_ok(flt_rtr_ok),
    .flt_id(flt_id), .flt_ide(flt_ide), .tx_req(tx_req), .fifo_wr(fifo_wr),
    .fifo_idx(fifo_idx)
  );

  int n_run = 0, n_bad = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic [IW-1:0] id;
    logic          ide;
    logic          rtr;
    logic [3:0]    dlc;
    logic          fen;
    logic [3:0]    tx;
    logic          wr;
    logic [1:0]    idx;
    logic [7:0]    req;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{29'h123,      1'b0, 1'b1, 4'd0,  1'b0, 4'b0101, 1'b0, 2'd0, 8'd7},   // R7 R2 R11
    '{29'h123,      1'b0, 1'b1, 4'd0,  1'b1, 4'b0000, 1'b1, 2'd3, 8'd8},   // R8
    '{29'h123,      1'b0, 1'b0, 4'd8,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd4},   // R4
    '{29'h122,      1'b0, 1'b1, 4'd0,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd3},   // R3
    '{29'h123,      1'b1, 1'b1, 4'd0,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd3},   // R3 IDE
    '{29'h0ABCDEF0, 1'b1, 1'b1, 4'd15, 1'b0, 4'b0010, 1'b0, 2'd0, 8'd5},   // R5
    '{29'h0ABCDEF0, 1'b1, 1'b1, 4'd3,  1'b1, 4'b0010, 1'b0, 2'd0, 8'd9},   // R9
    '{29'h0ABCDEF1, 1'b1, 1'b1, 4'd0,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd3},   // R3 lsb
    '{29'h055,      1'b0, 1'b1, 4'd0,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd6},   // R6
    '{29'h0AB07FFF, 1'b1, 1'b1, 4'd0,  1'b1, 4'b0000, 1'b1, 2'd1, 8'd12},  // R12 B
    '{29'h0AB08000, 1'b1, 1'b1, 4'd0,  1'b1, 4'b0000, 1'b0, 2'd0, 8'd12},  // R12 B edge
    '{29'h1F1FFFFF, 1'b1, 1'b1, 4'd0,  1'b1, 4'b0000, 1'b1, 2'd2, 8'd10},  // R10
    '{29'h1F200000, 1'b1, 1'b1, 4'd0,  1'b1, 4'b0000, 1'b0, 2'd0, 8'd12},  // R12 C edge
    '{29'h1F000000, 1'b1, 1'b0, 4'd0,  1'b1, 4'b0000, 1'b0, 2'd0, 8'd4},   // R4
    '{29'h0AB07FFF, 1'b1, 1'b1, 4'd0,  1'b0, 4'b0000, 1'b0, 2'd0, 8'd11}   // R11
  };

  task automatic chk(input string rq, input logic [3:0] etx, input logic ewr,
                     input logic [1:0] eidx, input logic use_idx);
    n_run++;
    if (tx_req !== etx || fifo_wr !== ewr || (use_idx && fifo_idx !== eidx)) begin
      n_bad++;
      $display("FAIL %s: tx_req=%b fifo_wr=%b idx=%0d expected tx_req=%b fifo_wr=%b idx=%0d",
               rq, tx_req, fifo_wr, fifo_idx, etx, ewr, eidx);
    end
  endtask

  // frame in, check that nothing appears after one edge, sample after two,
  // then confirm the pulse is gone
  task automatic send(input logic [IW-1:0] id, input logic ide, input logic rtr,
                      input logic [3:0] dlc, input logic fen, input string rq,
                      input logic [3:0] etx, input logic ewr, input logic [1:0] eidx);
    @(negedge clk);
    rx_id = id; rx_ide = ide; rx_rtr = rtr; rx_dlc = dlc; fifo_en = fen;
    rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    chk({rq, " latency"}, 4'b0000, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    chk(rq, etx, ewr, eidx, ewr);
    @(negedge clk);
    chk({rq, " pulse end"}, 4'b0000, 1'b0, 2'd0, 1'b0);
  endtask

  initial begin
    mb_rr_en = 4'b0111;
    mb_ide   = 4'b0010;
    mb_id    = {29'h055, 29'h123, 29'h0ABCDEF0, 29'h123};
    flt_fmt  = {2'b00, 2'b10, 2'b01, 2'b00};
    flt_rtr_ok = 4'b1010;
    flt_ide  = 4'b0111;
    flt_id   = {29'h123, 29'h1F000000, 29'h0AB00000, 29'h0ABCDEF0};

    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b0000, 1'b0, 2'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", 4'b0000, 1'b0, 2'd0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      send(VECS[v].id, VECS[v].ide, VECS[v].rtr, VECS[v].dlc, VECS[v].fen,
           $sformatf("R%0d vec%0d", VECS[v].req, v),
           VECS[v].tx, VECS[v].wr, VECS[v].idx);
    end

    // R12: reserved code on filter 3 never matches, reply goes out
    flt_fmt[7:6] = 2'b11;
    send(29'h123, 1'b0, 1'b1, 4'd0, 1'b1, "R12 reserved", 4'b0101, 1'b0, 2'd0);

    // R8: two filters accept, lowest index reported
    flt_fmt[7:6] = 2'b00;
    flt_fmt[1:0] = 2'b00;
    flt_id[28:0] = 29'h123;
    flt_ide[0]   = 1'b0;
    flt_rtr_ok[0] = 1'b1;
    send(29'h123, 1'b0, 1'b1, 4'd0, 1'b1, "R8 lowest", 4'b0000, 1'b1, 2'd0);

    // R9: filter 0 format A with remote refused, filter 3 still takes it
    flt_rtr_ok[0] = 1'b0;
    send(29'h123, 1'b0, 1'b1, 4'd0, 1'b1, "R9 refuse", 4'b0000, 1'b1, 2'd3);

    // R6: enable mailbox 3, then it answers
    mb_rr_en = 4'b1000;
    send(29'h055, 1'b0, 1'b1, 4'd2, 1'b0, "R6 enabled", 4'b1000, 1'b0, 2'd0);

    // R2: back-to-back distinct frames each get their own pulse
    mb_rr_en = 4'b0111;
    @(negedge clk);
    rx_id = 29'h123; rx_ide = 1'b0; rx_rtr = 1'b1; fifo_en = 1'b0; rx_valid = 1'b1;
    @(negedge clk);
    rx_id = 29'h0ABCDEF0; rx_ide = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R2 b2b first", 4'b0101, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    chk("R2 b2b second", 4'b0010, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    chk("R2 b2b idle", 4'b0000, 1'b0, 2'd0, 1'b0);

    // R1: reset mid-flight clears the pipeline
    @(negedge clk);
    rx_id = 29'h123; rx_ide = 1'b0; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 flush", 4'b0000, 1'b0, 2'd0, 1'b0);
    @(negedge clk);
    chk("R1 flush idle", 4'b0000, 1'b0, 2'd0, 1'b0);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++;
      n_bad++;
      $display("FAIL watchdog: done=0 expected done=1");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule